// File: doc/BRIEF.md
# NOR Flash Array Program/Erase Controller

This block is the storage back end that sits behind a serial flash command engine. It holds a byte array organised as equal sectors and accepts two kinds of request from the engine: a byte program, which carries an address and a data byte, and an erase, which carries a region kind and an address. The engine also supplies its current write-enable state. A combinational read port returns the stored byte at any address.

Programming follows NOR flash rules. A program can only turn 1 bits into 0 bits, so the stored byte becomes the old value ANDed with the new one. A parameter selects EEPROM behaviour instead, in which a program overwrites the byte freely. Four erase kinds are supported: a small subsector, a larger block, a sector, or the whole chip. Each kind fills its region with 0xFF. The subsector and block kinds can be switched off per device through a capability mask.

A refused request leaves the array untouched and raises a one-cycle error pulse. Refusal happens when write-enable is low or when the erase size is not supported. A sticky warning records any accepted flash-mode program that tried to raise a 0 bit back to 1. The region sizes are parameters; in a real device they would be 4 KiB, 32 KiB and 64 KiB or 256 KiB. The defaults are kept small so that the whole array can be swept quickly.

Top module: `nor_array_ctrl`

## Requirements
- R1: After reset every byte reads 0xFF, `req_error` is 0 and `zero_to_one_warn` is 0.
- R2: With `EEPROM_MODE`=0, an accepted program stores (old AND `prog_data`) at `prog_addr`. The new value is visible on `rd_data` from the clock edge that takes the request.
- R3: `zero_to_one_warn` is set by an accepted flash-mode program whose data has a 1 bit where the stored byte has a 0. Once set, it stays set until reset. It is never set when `EEPROM_MODE`=1.
- R4: With `EEPROM_MODE`=1, an accepted program stores `prog_data` unchanged.
- R5: A program request made while `write_enable` is 0 leaves the array unchanged.
- R6: `erase_kind` encodes the region to erase: 0 selects a subsector of `SUB_BYTES`, 1 a block of `BLK_BYTES`, 2 a sector of `SECTOR_BYTES`, and 3 the whole array. An accepted erase sets every byte of the region to 0xFF.
- R7: The erased region starts at `erase_addr` aligned down to the region size. Bytes outside the region keep their values.
- R8: `ERASE_CAPS` bit 0 permits kind 0 and bit 1 permits kind 1. An erase of a kind whose bit is 0 is refused and leaves the array unchanged.
- R9: An erase request made while `write_enable` is 0 is refused and leaves the array unchanged.
- R10: `req_error` is 1 for exactly the cycle after a refused program or erase, and is 0 otherwise.
- R11: When program and erase are requested in the same cycle, the erase is handled as usual. The program is dropped without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| write_enable | input | 1 | Write-enable state from the command engine |
| prog_req | input | 1 | Byte program request |
| prog_addr | input | AW | Program byte address |
| prog_data | input | 8 | Program data byte |
| erase_req | input | 1 | Erase request |
| erase_kind | input | 2 | Erase region kind (0 subsector, 1 block, 2 sector, 3 chip) |
| erase_addr | input | AW | Any address inside the region to erase |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Stored byte at `rd_addr` |
| req_error | output | 1 | One-cycle pulse after a refused request |
| zero_to_one_warn | output | 1 | Sticky flag for a flash-mode attempt to program a 0 bit to 1 |

## Verification
The bench drives one flash-mode instance and one EEPROM-mode instance with the same stimulus. After every phase it compares every byte of both arrays against its own models.

Unaligned erase addresses are used to catch a design that erases from the given address instead of the aligned base; such a design would leave the lower part of the region stale and wipe bytes of the next region. A block erase is sent to an instance that lacks the capability; a design that ignored the mask would erase it. A program of 0xFF onto cleared bits is used to catch a design that overwrites in flash mode or forgets the warning. Requests with write-enable low and simultaneous program/erase requests are used to catch a design that lets a refused or dropped write reach the array, or that mistimes the error pulse.

// File: rtl/nor_array_ctrl.sv
module nor_array_ctrl #(
  parameter int       SUB_BYTES    = 16,
  parameter int       BLK_BYTES    = 64,
  parameter int       SECTOR_BYTES = 128,
  parameter int       NUM_SECTORS  = 8,
  parameter bit       EEPROM_MODE  = 1'b0,
  parameter bit [1:0] ERASE_CAPS   = 2'b11,
  localparam int      DEPTH        = SECTOR_BYTES * NUM_SECTORS,
  localparam int      AW           = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          write_enable,
  input  logic          prog_req,
  input  logic [AW-1:0] prog_addr,
  input  logic [7:0]    prog_data,
  input  logic          erase_req,
  input  logic [1:0]    erase_kind,
  input  logic [AW-1:0] erase_addr,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          req_error,
  output logic          zero_to_one_warn
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] span;
  logic [AW-1:0] base;
  logic [7:0]    old_byte;
  logic [7:0]    new_byte;
  logic          cap_ok, erase_go, prog_go, refused, raises_bit;

  always_comb begin
    case (erase_kind)
      2'd0:    span = AW'(SUB_BYTES - 1);
      2'd1:    span = AW'(BLK_BYTES - 1);
      2'd2:    span = AW'(SECTOR_BYTES - 1);
      default: span = '1;
    endcase
  end

  assign base       = erase_addr & ~span;
  assign cap_ok     = (erase_kind == 2'd0) ? ERASE_CAPS[0] :
                      (erase_kind == 2'd1) ? ERASE_CAPS[1] : 1'b1;
  assign erase_go   = erase_req && write_enable && cap_ok;
  assign prog_go    = prog_req && !erase_req && write_enable;
  assign refused    = (erase_req && !erase_go) ||
                      (prog_req && !erase_req && !write_enable);
  assign old_byte   = mem[prog_addr];
  assign new_byte   = EEPROM_MODE ? prog_data : (old_byte & prog_data);
  assign raises_bit = !EEPROM_MODE && ((prog_data & ~old_byte) != 8'h00);
  assign rd_data    = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (erase_go) begin
      for (int i = 0; i < DEPTH; i++)
        if ((AW'(i) & ~span) == base) mem[i] <= 8'hFF;
    end else if (prog_go) begin
      mem[prog_addr] <= new_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_error        <= 1'b0;
      zero_to_one_warn <= 1'b0;
    end else begin
      req_error <= refused;
      if (prog_go && raises_bit) zero_to_one_warn <= 1'b1;
    end
  end

endmodule

module nor_array_ctrl_chk #(
  parameter int       AW          = 10,
  parameter bit       EEPROM_MODE = 1'b0,
  parameter bit [1:0] ERASE_CAPS  = 2'b11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          write_enable,
  input logic          prog_req,
  input logic [AW-1:0] prog_addr,
  input logic [7:0]    prog_data,
  input logic          erase_req,
  input logic [1:0]    erase_kind,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    rd_data,
  input logic          req_error,
  input logic          zero_to_one_warn
);

  assert_prog_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req && !erase_req && !write_enable |=> req_error);

  assert_erase_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req && !write_enable |=> req_error);

  assert_cap_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req && write_enable &&
    ((erase_kind == 2'd0 && !ERASE_CAPS[0]) || (erase_kind == 2'd1 && !ERASE_CAPS[1]))
    |=> req_error);

  assert_error_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_error |-> $past(prog_req || erase_req));

  assert_warn_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    zero_to_one_warn |=> zero_to_one_warn);

  assert_chip_erase_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req && erase_kind == 2'd3 && write_enable |=> rd_data == 8'hFF);

  assert_flash_and_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !EEPROM_MODE && prog_req && !erase_req && write_enable && prog_addr == rd_addr
    |=> (!$stable(rd_addr) || rd_data == ($past(rd_data) & $past(prog_data))));

  assert_eeprom_overwrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    EEPROM_MODE && prog_req && !erase_req && write_enable && prog_addr == rd_addr
    |=> (!$stable(rd_addr) || rd_data == $past(prog_data)));

endmodule

bind nor_array_ctrl nor_array_ctrl_chk #(
  .AW(AW), .EEPROM_MODE(EEPROM_MODE), .ERASE_CAPS(ERASE_CAPS)
) chk (
  .clk(clk), .rst_n(rst_n), .write_enable(write_enable), .prog_req(prog_req),
  .prog_addr(prog_addr), .prog_data(prog_data), .erase_req(erase_req),
  .erase_kind(erase_kind), .rd_addr(rd_addr), .rd_data(rd_data),
  .req_error(req_error), .zero_to_one_warn(zero_to_one_warn)
);

// File: tb/nor_array_ctrl_test.sv
module nor_array_ctrl_test;
  localparam int DEPTH = 1024;
  localparam int AW    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0, pr = 1'b0, er = 1'b0;
  logic [AW-1:0] pa = '0, ea = '0, ra = '0;
  logic [7:0] pd = '0;
  logic [1:0] ek = '0;
  logic [7:0] rd [2];
  logic err [2];
  logic warn [2];

  logic [7:0] mdl [2][DEPTH];
  logic       wexp [2];
  bit   [1:0] caps [2] = '{2'b01, 2'b11};
  bit         eem  [2] = '{1'b0, 1'b1};
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nor_array_ctrl #(.EEPROM_MODE(1'b0), .ERASE_CAPS(2'b01)) uut (
    .clk(clk), .rst_n(rst_n), .write_enable(we), .prog_req(pr), .prog_addr(pa),
    .prog_data(pd), .erase_req(er), .erase_kind(ek), .erase_addr(ea),
    .rd_addr(ra), .rd_data(rd[0]), .req_error(err[0]), .zero_to_one_warn(warn[0]));

  nor_array_ctrl #(.EEPROM_MODE(1'b1), .ERASE_CAPS(2'b11)) uut_ee (
    .clk(clk), .rst_n(rst_n), .write_enable(we), .prog_req(pr), .prog_addr(pa),
    .prog_data(pd), .erase_req(er), .erase_kind(ek), .erase_addr(ea),
    .rd_addr(ra), .rd_data(rd[1]), .req_error(err[1]), .zero_to_one_warn(warn[1]));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sweep(string tag);
    for (int a = 0; a < DEPTH; a++) begin
      ra = AW'(a);
      #1;
      for (int u = 0; u < 2; u++) check(tag, rd[u], mdl[u][a]);
    end
  endtask

  task automatic op(string tag, logic w, logic p, int a, int d, logic e, int k, int eaddr);
    logic eerr [2];
    int span;
    span = (k == 0) ? 15 : (k == 1) ? 63 : (k == 2) ? 127 : DEPTH - 1;
    for (int u = 0; u < 2; u++) begin
      logic cap;
      cap = (k == 0) ? caps[u][0] : (k == 1) ? caps[u][1] : 1'b1;
      eerr[u] = (e && !(w && cap)) || (p && !e && !w);
      if (e && w && cap) begin
        for (int i = 0; i < DEPTH; i++)
          if ((i & ~span) == (eaddr & ~span)) mdl[u][i] = 8'hFF;
      end else if (p && !e && w) begin
        if (!eem[u] && ((d & ~mdl[u][a]) & 8'hFF) != 0) wexp[u] = 1'b1;
        mdl[u][a] = eem[u] ? 8'(d) : (mdl[u][a] & 8'(d));
      end
    end
    we = w; pr = p; pa = AW'(a); pd = 8'(d); er = e; ek = 2'(k); ea = AW'(eaddr);
    @(posedge clk);
    @(negedge clk);
    pr = 1'b0; er = 1'b0;
    for (int u = 0; u < 2; u++) begin
      check({tag, " err R10"}, err[u], eerr[u]);
      check({tag, " warn R3"}, warn[u], wexp[u]);
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int u = 0; u < 2; u++) begin
      wexp[u] = 1'b0;
      for (int i = 0; i < DEPTH; i++) mdl[u][i] = 8'hFF;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    for (int u = 0; u < 2; u++) begin
      check("R1 err", err[u], 0);
      check("R1 warn", warn[u], 0);
    end
    sweep("R1 reset fill");

    op("R5 prog no-we", 1'b0, 1'b1, 5, 8'h00, 1'b0, 0, 0);
    sweep("R5 array untouched");
    @(negedge clk);
    for (int u = 0; u < 2; u++) check("R10 err one cycle", err[u], 0);

    for (int a = 0; a < DEPTH; a++)
      op("R2 R4 prog pass1", 1'b1, 1'b1, a, (a * 7 + 3) & 8'hFF, 1'b0, 0, 0);
    sweep("R2 R4 after pass1");

    op("R3 raise bits", 1'b1, 1'b1, 12'h040, 8'hFF, 1'b0, 0, 0);
    for (int a = 0; a < 256; a++)
      op("R2 R4 prog pass2", 1'b1, 1'b1, a * 3, (~a) & 8'hFF, 1'b0, 0, 0);
    sweep("R2 R3 R4 after pass2");

    op("R6 R7 subsector", 1'b1, 1'b0, 0, 0, 1'b1, 0, 12'h123);
    sweep("R6 R7 subsector region");
    op("R8 block caps", 1'b1, 1'b0, 0, 0, 1'b1, 1, 12'h0C5);
    sweep("R8 block refused or done");
    op("R6 R7 sector", 1'b1, 1'b0, 0, 0, 1'b1, 2, 12'h2A7);
    sweep("R6 R7 sector region");
    op("R9 erase no-we", 1'b0, 1'b0, 0, 0, 1'b1, 3, 0);
    sweep("R9 array untouched");
    op("R11 prog+erase", 1'b1, 1'b1, 12'h300, 8'h00, 1'b1, 0, 12'h010);
    sweep("R11 prog dropped");
    op("R11 prog+refused erase", 1'b0, 1'b1, 12'h301, 8'h00, 1'b1, 2, 12'h300);
    sweep("R11 nothing written");
    op("R6 chip erase", 1'b1, 1'b0, 0, 0, 1'b1, 3, 12'h1FF);
    sweep("R6 chip all FF");
    @(negedge clk);
    for (int u = 0; u < 2; u++) check("R3 warn still sticky", warn[u], wexp[u]);

    do_reset();
    @(negedge clk);
    for (int u = 0; u < 2; u++) check("R1 warn cleared", warn[u], 0);
    sweep("R1 reset refill");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule